// File: doc/BRIEF.md
# Interrupt Destination Resolver

This block turns an interprocessor interrupt command into a set of target units and a delivery action. A command is held as two 32-bit words. The high word carries the destination. Writing the low word launches one resolution. The resolver compares the destination against the ID, logical ID and destination format of every local interrupt unit. It then applies the shorthand, if any, and decides what kind of event the targets receive: an ordinary delivery, a startup event, or a reload of their arbitration IDs.

The result appears one cycle after the low-word write and lasts for exactly one cycle. It consists of a per-unit mask, the vector, the delivery mode and the trigger mode, plus one flag for each kind of event. The units themselves, and how they raise interrupts, are outside this block. The number of units is a parameter and defaults to 8.

Top module: `idr_resolver`

## Requirements
- R1: A cycle with `cmd_lo_we` high produces `res_valid` high in the next cycle only. In every cycle where `res_valid` is low, the mask, vector, mode, trigger and all three event flags are zero. After reset all outputs are zero. A write of the high word alone produces no strobe.
- R2: The low word is decoded as follows: vector in bits 7:0, delivery mode in bits 10:8, logical addressing in bit 11, level in bit 14, trigger in bit 15, shorthand in bits 19:18. All other low-word bits are ignored. The destination is bits 31:24 of the last high word written. A high-word write in the same cycle as a low-word write is used by that command.
- R3: Shorthand 1 targets only the unit at `sender_idx`. Shorthand 2 targets every unit. Shorthand 3 targets every unit except the sender. Shorthand 0 uses the addressed destination.
- R4: In physical addressing (bit 11 = 0), destination 0xFF targets every unit. Any other destination targets the lowest-indexed unit whose ID equals it, or no unit if no ID matches.
- R5: In logical addressing, a unit whose format is 0xF matches when the bitwise AND of the destination and its logical ID is nonzero.
- R6: In logical addressing, a unit whose format is 0x0 matches when the upper nibbles of the destination and its logical ID are equal and the lower nibbles share a set bit. A unit with any other format never matches.
- R7: Delivery mode 1 (lowest priority) sets `res_deliver`. Its mask holds only the lowest-indexed target, or is zero if there are no targets. The vector and trigger are passed through.
- R8: Mode 5 with level 0 and trigger 1 sets only `res_arb_load`. The mask holds the targets and the vector and trigger are zero. The three event flags are never high together.
- R9: Mode 6 sets only `res_startup`. The mask holds the targets, the vector is passed through and the trigger is zero.
- R10: Modes 2 and 4, and mode 5 in every other level/trigger combination, set `res_deliver`. The mask holds the targets and the vector and trigger are zero.
- R11: Mode 3 is reserved. It gives a strobe with a zero mask, zero vector, zero trigger and no event flag.
- R12: Modes 0 and 7 set `res_deliver`. The mask holds the full target set and the vector and trigger bit are passed through. `res_mode` always echoes the command's mode field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_lo_we | input | 1 | Low command word write; starts a resolution |
| cmd_lo | input | 32 | Low command word |
| cmd_hi_we | input | 1 | High command word write |
| cmd_hi | input | 32 | High command word (destination in 31:24) |
| sender_idx | input | $clog2(N_UNITS) | Index of the issuing unit |
| unit_id | input | N_UNITS*8 | Per-unit ID, unit i in bits i*8 +: 8 |
| unit_ldest | input | N_UNITS*8 | Per-unit logical ID |
| unit_fmt | input | N_UNITS*4 | Per-unit destination format |
| res_valid | output | 1 | One-cycle result strobe |
| res_mask | output | N_UNITS | Units receiving the event |
| res_vector | output | 8 | Vector for the event |
| res_mode | output | 3 | Echo of the delivery mode field |
| res_trig | output | 1 | Trigger mode for vectored deliveries |
| res_deliver | output | 1 | Ordinary delivery event |
| res_startup | output | 1 | Startup event |
| res_arb_load | output | 1 | Arbitration-ID reload event |

## Verification
Every result is due in the first cycle after the edge that sampled `cmd_lo_we`. The bench therefore drives each command on a falling edge and reads every output on the following falling edge, after exactly one rising edge. Each output is also quiet again one edge later, and the bench checks this idle cycle explicitly, as well as the cycle after a high-word write alone. A high-word write that shares an edge with the low word takes effect in that same result. The bench sweeps every destination, shorthand, addressing mode and delivery mode against two unit configurations. One configuration has duplicate IDs and formats that are neither flat nor cluster.

// File: rtl/idr_pkg.sv
package idr_pkg;
  localparam int CMD_W      = 32;
  localparam int ID_W       = 8;
  localparam int FMT_W      = 4;
  localparam int VEC_W      = 8;
  localparam int MODE_W     = 3;
  localparam int VEC_LSB    = 0;
  localparam int MODE_LSB   = 8;
  localparam int LOGDST_BIT = 11;
  localparam int LEVEL_BIT  = 14;
  localparam int TRIG_BIT   = 15;
  localparam int SH_LSB     = 18;
  localparam int DEST_LSB   = 24;
  localparam int NIB_W      = ID_W / 2;

  localparam logic [FMT_W-1:0] FMT_FLAT    = 4'hF;
  localparam logic [FMT_W-1:0] FMT_CLUSTER = 4'h0;

  typedef enum logic [1:0] {
    SH_NONE   = 2'd0,
    SH_SELF   = 2'd1,
    SH_ALL    = 2'd2,
    SH_OTHERS = 2'd3
  } shorthand_e;

  typedef enum logic [MODE_W-1:0] {
    DM_FIXED  = 3'd0,
    DM_LOWEST = 3'd1,
    DM_SMI    = 3'd2,
    DM_RSVD   = 3'd3,
    DM_NMI    = 3'd4,
    DM_INIT   = 3'd5,
    DM_START  = 3'd6,
    DM_EXT    = 3'd7
  } dmode_e;

  typedef struct packed {
    logic [VEC_W-1:0] vector;
    dmode_e           mode;
    logic             log_mode;
    logic             level;
    logic             trig;
    shorthand_e       sh;
  } cmd_t;

  function automatic cmd_t unpack_cmd(input logic [CMD_W-1:0] w);
    cmd_t c;
    c.vector   = w[VEC_LSB +: VEC_W];
    c.mode     = dmode_e'(w[MODE_LSB +: MODE_W]);
    c.log_mode = w[LOGDST_BIT];
    c.level    = w[LEVEL_BIT];
    c.trig     = w[TRIG_BIT];
    c.sh       = shorthand_e'(w[SH_LSB +: 2]);
    return c;
  endfunction

  // flat logical: any shared bit
  function automatic logic flat_hit(input logic [ID_W-1:0] dest,
                                    input logic [ID_W-1:0] ldest);
    return |(dest & ldest);
  endfunction

  // cluster logical: equal cluster nibble, overlapping member nibble
  function automatic logic cluster_hit(input logic [ID_W-1:0] dest,
                                       input logic [ID_W-1:0] ldest);
    return (dest[ID_W-1:NIB_W] == ldest[ID_W-1:NIB_W]) &&
           (|(dest[NIB_W-1:0] & ldest[NIB_W-1:0]));
  endfunction

  // INIT with level low and trigger high reloads arbitration IDs
  function automatic logic is_arb_reload(input cmd_t c);
    return (c.mode == DM_INIT) && !c.level && c.trig;
  endfunction
endpackage

// File: rtl/idr_unit_match.sv
module idr_unit_match
  import idr_pkg::*;
(
  input  logic [ID_W-1:0]  dest,
  input  logic [ID_W-1:0]  id,
  input  logic [ID_W-1:0]  ldest,
  input  logic [FMT_W-1:0] fmt,
  output logic             id_hit,
  output logic             log_hit
);
  assign id_hit = (id == dest);

  always_comb begin
    case (fmt)
      FMT_FLAT:    log_hit = flat_hit(dest, ldest);
      FMT_CLUSTER: log_hit = cluster_hit(dest, ldest);
      default:     log_hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/idr_target_gen.sv
module idr_target_gen
  import idr_pkg::*;
#(
  parameter int N_UNITS = 8
) (
  input  shorthand_e                   sh,
  input  logic                         log_mode,
  input  logic [ID_W-1:0]              dest,
  input  logic [$clog2(N_UNITS)-1:0]   sender_idx,
  input  logic [N_UNITS*ID_W-1:0]      unit_id,
  input  logic [N_UNITS*ID_W-1:0]      unit_ldest,
  input  logic [N_UNITS*FMT_W-1:0]     unit_fmt,
  output logic [N_UNITS-1:0]           target_mask
);
  localparam int IDX_W = $clog2(N_UNITS);

  logic [N_UNITS-1:0] id_hit;
  logic [N_UNITS-1:0] log_hit;
  logic [N_UNITS-1:0] self_mask;
  logic [N_UNITS-1:0] first_id_hit;
  logic [N_UNITS-1:0] addr_mask;

  for (genvar g = 0; g < N_UNITS; g++) begin : g_unit
    idr_unit_match u_match (
      .dest    (dest),
      .id      (unit_id[g*ID_W +: ID_W]),
      .ldest   (unit_ldest[g*ID_W +: ID_W]),
      .fmt     (unit_fmt[g*FMT_W +: FMT_W]),
      .id_hit  (id_hit[g]),
      .log_hit (log_hit[g])
    );
    assign self_mask[g] = (sender_idx == IDX_W'(g));
  end

  // isolate lowest set bit of the ID matches
  assign first_id_hit = id_hit & (~id_hit + 1'b1);

  always_comb begin
    if (log_mode)               addr_mask = log_hit;
    else if (dest == '1)        addr_mask = '1;
    else                        addr_mask = first_id_hit;
  end

  always_comb begin
    case (sh)
      SH_SELF:   target_mask = self_mask;
      SH_ALL:    target_mask = '1;
      SH_OTHERS: target_mask = ~self_mask;
      default:   target_mask = addr_mask;
    endcase
  end
endmodule

// File: rtl/idr_action.sv
module idr_action
  import idr_pkg::*;
#(
  parameter int N_UNITS = 8
) (
  input  cmd_t                 cmd,
  input  logic [N_UNITS-1:0]   targets,
  output logic [N_UNITS-1:0]   act_mask,
  output logic [VEC_W-1:0]     act_vector,
  output logic                 act_trig,
  output logic                 act_deliver,
  output logic                 act_startup,
  output logic                 act_arb_load
);
  logic [N_UNITS-1:0] lowest_target;
  assign lowest_target = targets & (~targets + 1'b1);

  always_comb begin
    act_mask     = '0;
    act_vector   = '0;
    act_trig     = 1'b0;
    act_deliver  = 1'b0;
    act_startup  = 1'b0;
    act_arb_load = 1'b0;
    case (cmd.mode)
      DM_FIXED, DM_EXT: begin
        act_deliver = 1'b1;
        act_mask    = targets;
        act_vector  = cmd.vector;
        act_trig    = cmd.trig;
      end
      DM_LOWEST: begin
        act_deliver = 1'b1;
        act_mask    = lowest_target;
        act_vector  = cmd.vector;
        act_trig    = cmd.trig;
      end
      DM_SMI, DM_NMI: begin
        act_deliver = 1'b1;
        act_mask    = targets;
      end
      DM_INIT: begin
        act_mask = targets;
        if (is_arb_reload(cmd)) act_arb_load = 1'b1;
        else                    act_deliver  = 1'b1;
      end
      DM_START: begin
        act_startup = 1'b1;
        act_mask    = targets;
        act_vector  = cmd.vector;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/idr_resolver.sv
module idr_resolver
  import idr_pkg::*;
#(
  parameter int N_UNITS = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cmd_lo_we,
  input  logic [31:0]                   cmd_lo,
  input  logic                          cmd_hi_we,
  input  logic [31:0]                   cmd_hi,
  input  logic [$clog2(N_UNITS)-1:0]    sender_idx,
  input  logic [N_UNITS*8-1:0]          unit_id,
  input  logic [N_UNITS*8-1:0]          unit_ldest,
  input  logic [N_UNITS*4-1:0]          unit_fmt,
  output logic                          res_valid,
  output logic [N_UNITS-1:0]            res_mask,
  output logic [7:0]                    res_vector,
  output logic [2:0]                    res_mode,
  output logic                          res_trig,
  output logic                          res_deliver,
  output logic                          res_startup,
  output logic                          res_arb_load
);
  logic [ID_W-1:0]    dest_q;
  logic [ID_W-1:0]    dest_eff;
  cmd_t               cmd;
  logic [N_UNITS-1:0] target_mask;
  logic [N_UNITS-1:0] act_mask;
  logic [VEC_W-1:0]   act_vector;
  logic               act_trig;
  logic               act_deliver;
  logic               act_startup;
  logic               act_arb_load;
  logic               unused_cmd_bits;

  assign unused_cmd_bits = ^{cmd_hi[DEST_LSB-1:0], cmd_lo[31:20], cmd_lo[17:16],
                             cmd_lo[13:12]};

  always_ff @(posedge clk) begin
    if (!rst_n)         dest_q <= '0;
    else if (cmd_hi_we) dest_q <= cmd_hi[DEST_LSB +: ID_W];
  end

  // a same-cycle high write is forwarded to the command
  assign dest_eff = cmd_hi_we ? cmd_hi[DEST_LSB +: ID_W] : dest_q;
  assign cmd      = unpack_cmd(cmd_lo);

  idr_target_gen #(.N_UNITS(N_UNITS)) u_targets (
    .sh          (cmd.sh),
    .log_mode    (cmd.log_mode),
    .dest        (dest_eff),
    .sender_idx  (sender_idx),
    .unit_id     (unit_id),
    .unit_ldest  (unit_ldest),
    .unit_fmt    (unit_fmt),
    .target_mask (target_mask)
  );

  idr_action #(.N_UNITS(N_UNITS)) u_action (
    .cmd          (cmd),
    .targets      (target_mask),
    .act_mask     (act_mask),
    .act_vector   (act_vector),
    .act_trig     (act_trig),
    .act_deliver  (act_deliver),
    .act_startup  (act_startup),
    .act_arb_load (act_arb_load)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || !cmd_lo_we) begin
      res_valid    <= 1'b0;
      res_mask     <= '0;
      res_vector   <= '0;
      res_mode     <= '0;
      res_trig     <= 1'b0;
      res_deliver  <= 1'b0;
      res_startup  <= 1'b0;
      res_arb_load <= 1'b0;
    end else begin
      res_valid    <= 1'b1;
      res_mask     <= act_mask;
      res_vector   <= act_vector;
      res_mode     <= cmd.mode;
      res_trig     <= act_trig;
      res_deliver  <= act_deliver;
      res_startup  <= act_startup;
      res_arb_load <= act_arb_load;
    end
  end
endmodule

// File: rtl/idr_resolver_chk.sv
module idr_resolver_chk #(
  parameter int N_UNITS = 8
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        cmd_lo_we,
  input logic [31:0]                 cmd_lo,
  input logic [$clog2(N_UNITS)-1:0]  sender_idx,
  input logic [N_UNITS-1:0]          target_mask,
  input logic                        res_valid,
  input logic [N_UNITS-1:0]          res_mask,
  input logic [7:0]                  res_vector,
  input logic [2:0]                  res_mode,
  input logic                        res_deliver,
  input logic                        res_startup,
  input logic                        res_arb_load
);
  p_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_lo_we |=> res_valid);

  p_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> (res_mask == '0 && res_vector == '0 && !res_deliver &&
                    !res_startup && !res_arb_load));

  p_self_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_lo_we && cmd_lo[19:18] == 2'd1) |=>
      ($countones(res_mask) <= 1 && (res_mask == '0 || res_mask[$past(sender_idx)])));

  p_skip_sender_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_lo_we && cmd_lo[19:18] == 2'd3) |=> !res_mask[$past(sender_idx)]);

  p_lowest_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_deliver && res_mode == 3'd1) |-> $onehot0(res_mask));

  p_kind_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({res_deliver, res_startup, res_arb_load}) <= 1);

  p_novector_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && (res_mode == 3'd2 || res_mode == 3'd4)) |-> res_vector == 8'd0);

  p_reserved_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_lo_we && cmd_lo[10:8] == 3'd3) |=>
      (res_valid && res_mask == '0 && !res_deliver && !res_startup && !res_arb_load));

  p_fixed_full_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_lo_we && cmd_lo[10:8] == 3'd0) |=> res_mask == $past(target_mask));
endmodule

bind idr_resolver idr_resolver_chk #(.N_UNITS(N_UNITS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cmd_lo_we    (cmd_lo_we),
  .cmd_lo       (cmd_lo),
  .sender_idx   (sender_idx),
  .target_mask  (target_mask),
  .res_valid    (res_valid),
  .res_mask     (res_mask),
  .res_vector   (res_vector),
  .res_mode     (res_mode),
  .res_deliver  (res_deliver),
  .res_startup  (res_startup),
  .res_arb_load (res_arb_load)
);

// File: tb/idr_resolver_tb_top.sv
module idr_resolver_tb_top;
  localparam int N = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic           rst_n = 1'b0;
  logic           cmd_lo_we = 1'b0, cmd_hi_we = 1'b0;
  logic [31:0]    cmd_lo = '0, cmd_hi = '0;
  logic [2:0]     sender_idx = '0;
  logic [N*8-1:0] unit_id, unit_ldest;
  logic [N*4-1:0] unit_fmt;
  logic           res_valid, res_trig, res_deliver, res_startup, res_arb_load;
  logic [N-1:0]   res_mask;
  logic [7:0]     res_vector;
  logic [2:0]     res_mode;

  logic [7:0] cfg_id [N];
  logic [7:0] cfg_ld [N];
  logic [3:0] cfg_fmt[N];

  always_comb begin
    for (int i = 0; i < N; i++) begin
      unit_id[i*8 +: 8]    = cfg_id[i];
      unit_ldest[i*8 +: 8] = cfg_ld[i];
      unit_fmt[i*4 +: 4]   = cfg_fmt[i];
    end
  end

  idr_resolver #(.N_UNITS(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_lo_we(cmd_lo_we), .cmd_lo(cmd_lo),
    .cmd_hi_we(cmd_hi_we), .cmd_hi(cmd_hi), .sender_idx(sender_idx),
    .unit_id(unit_id), .unit_ldest(unit_ldest), .unit_fmt(unit_fmt),
    .res_valid(res_valid), .res_mask(res_mask), .res_vector(res_vector),
    .res_mode(res_mode), .res_trig(res_trig), .res_deliver(res_deliver),
    .res_startup(res_startup), .res_arb_load(res_arb_load)
  );

  int n_run = 0, n_fail = 0;

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [N+15:0] observed();
    return {res_valid, res_mask, res_vector, res_mode, res_trig,
            res_deliver, res_startup, res_arb_load};
  endfunction

  function automatic logic [N-1:0] exp_targets(input logic [1:0] sh, input bit lg,
                                               input logic [7:0] d, input int snd);
    logic [N-1:0] m = '0;
    bit found = 0;
    for (int i = 0; i < N; i++) begin
      if (sh == 2'd1)      m[i] = (i == snd);
      else if (sh == 2'd2) m[i] = 1'b1;
      else if (sh == 2'd3) m[i] = (i != snd);
      else if (!lg) begin
        if (d == 8'hFF) m[i] = 1'b1;
        else if (!found && cfg_id[i] == d) begin m[i] = 1'b1; found = 1; end
      end else if (cfg_fmt[i] == 4'hF) m[i] = (d & cfg_ld[i]) != 0;
      else if (cfg_fmt[i] == 4'h0)
        m[i] = (d[7:4] == cfg_ld[i][7:4]) && ((d[3:0] & cfg_ld[i][3:0]) != 0);
    end
    return m;
  endfunction

  function automatic logic [N+15:0] expected(input logic [31:0] lo, input logic [7:0] d,
                                             input int snd);
    logic [2:0] md = lo[10:8];
    logic [N-1:0] t = exp_targets(lo[19:18], lo[11], d, snd);
    logic [N-1:0] m = '0;
    logic [7:0] v = '0;
    bit tr = 0, dl = 0, st = 0, ar = 0;
    case (md)
      3'd0, 3'd7: begin dl = 1; m = t; v = lo[7:0]; tr = lo[15]; end
      3'd1: begin
        dl = 1; v = lo[7:0]; tr = lo[15];
        for (int i = 0; i < N; i++) if (t[i]) begin m[i] = 1'b1; break; end
      end
      3'd2, 3'd4: begin dl = 1; m = t; end
      3'd5: begin m = t; if (!lo[14] && lo[15]) ar = 1; else dl = 1; end
      3'd6: begin st = 1; m = t; v = lo[7:0]; end
      default: ;
    endcase
    return {1'b1, m, v, md, tr, dl, st, ar};
  endfunction

  function automatic string tag(input logic [31:0] lo, input bit hw);
    string s;
    case (lo[19:18])
      2'd0:    s = lo[11] ? "R5 R6" : "R4";
      default: s = "R3";
    endcase
    case (lo[10:8])
      3'd0, 3'd7: s = {s, " R12"};
      3'd1:       s = {s, " R7"};
      3'd2, 3'd4: s = {s, " R10"};
      3'd5:       s = {s, (!lo[14] && lo[15]) ? " R8" : " R10"};
      3'd6:       s = {s, " R9"};
      default:    s = {s, " R11"};
    endcase
    if (hw) s = {s, " R2"};
    return s;
  endfunction

  task automatic issue(input logic [31:0] lo, input bit hw, input logic [31:0] hi,
                       input int snd);
    @(negedge clk);
    cmd_lo = lo; cmd_lo_we = 1'b1; cmd_hi = hi; cmd_hi_we = hw;
    sender_idx = 3'(snd);
    @(negedge clk);
    cmd_lo_we = 1'b0; cmd_hi_we = 1'b0;
  endtask

  task automatic set_cfg(input int which);
    for (int i = 0; i < N; i++) begin
      if (which == 0) begin
        cfg_id[i] = 8'(i * 17 + 3); cfg_ld[i] = 8'(1 << i); cfg_fmt[i] = 4'hF;
      end else begin
        cfg_id[i]  = (i == 1 || i == 3) ? 8'h05 : 8'(i * 9 + 32);
        cfg_ld[i]  = 8'(((i % 3) << 4) | (i + 1));
        cfg_fmt[i] = (i == 2) ? 4'h3 : ((i % 2 == 0) ? 4'hF : 4'h0);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL R1 watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    set_cfg(1);
    repeat (3) @(negedge clk);
    check(observed() == '0, "R1 reset state", 64'(observed()), 64'd0);
    rst_n = 1'b1;

    // high word alone: no strobe; later command uses the stored destination
    @(negedge clk); cmd_hi = 32'h0500_0000; cmd_hi_we = 1'b1;
    @(negedge clk); cmd_hi_we = 1'b0;
    check(observed() == '0, "R1 no strobe from high write", 64'(observed()), 64'd0);
    issue(32'hFFF0_3041, 1'b0, 32'h0, 0);
    check(observed() == expected(32'hFFF0_3041, 8'h05, 0), "R2 R4 stored dest, junk bits",
          64'(observed()), 64'(expected(32'hFFF0_3041, 8'h05, 0)));
    @(negedge clk);
    check(observed() == '0, "R1 strobe lasts one cycle", 64'(observed()), 64'd0);

    for (int c = 0; c < 2; c++) begin
      set_cfg(c);
      for (int d = 0; d < 256; d++) begin
        for (int sh = 0; sh < 4; sh++) begin
          for (int lg = 0; lg < 2; lg++) begin
            for (int md = 0; md < 8; md++) begin
              logic [31:0] lo;
              bit hw = (sh == 0 && lg == 0 && md == 0);
              int snd = (d + md + sh) % N;
              lo = {4'(d), 8'(d), 2'(sh), 2'b11, d[0], d[1], 2'(d >> 2), 1'(lg),
                    3'(md), 8'(d ^ 8'h5A)};
              issue(lo, hw, {8'(d), 24'hABCDEF}, snd);
              check(observed() == expected(lo, 8'(d), snd), tag(lo, hw),
                    64'(observed()), 64'(expected(lo, 8'(d), snd)));
            end
          end
        end
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule